// File: doc/BRIEF.md
# Power-Sourcing Port Autonomous Sequencer

This block is the control state machine for one power-sourcing Ethernet port running without a host. Once the start-up delay after reset has run out, it checks the signature resistance of whatever is attached. It then measures the classification current to decide the power class and closes the port power switch. While the port is powered it watches the measured port current, port voltage and a die over-temperature flag. It removes power on a timed overcurrent, on a timed under/over-voltage, on overheating, or when the load has gone away for the dropout time.

Analog sensing, current limiting and conversion happen elsewhere. Each measurement arrives as a digital value with a one-cycle valid strobe. Every timeout is counted in pulses of an external tick strobe, and each timeout length is a parameter. A failed signature either retries at once or waits out a back-off period, as chosen by an input. Overcurrent, voltage and thermal faults park the port in a fault state with an active-low interrupt until a software reset or a disable/enable of the port.

Top module: `poe_port_seq`

## Requirements
- R1: After reset the status is 0 (start-up), the switch is open, `irq_n` is 1 and the class is 0. After START_TICKS tick pulses the port goes to detection (status 2) if `port_en` is 1, or to disabled (status 1) if it is 0.
- R2: A signature (units of 100 Ω) from SIG_LO to SIG_HI inclusive (defaults 190 and 265) is accepted and moves the port to classification (status 4). Any other value is rejected.
- R3: Classification current (units of 0.1 mA) decodes as follows. Below 65 it is class 0. From 65 it is class 1, from 145 class 2, from 230 class 3 and from 330 class 4. At 480 and above it is class 0. The class latches on the classification strobe and the port powers up (status 5).
- R4: `pwr_en` is 1 only in the powered state, and the powered state is only entered from classification.
- R5: While powered, port current (0.1 mA units) above OC_LIM held for OC_TICKS ticks opens the switch and enters the overcurrent fault (status 8).
- R6: On a rejected signature with `backoff_sel` = 1 the port waits in back-off (status 3) for BACKOFF_TICKS ticks and then returns to detection. With `backoff_sel` = 0 it stays in detection.
- R7: While powered, current below DISC_LIM held for DISC_TICKS ticks removes power and returns to detection. When `disc_dis` is 1 this has no effect.
- R8: With `uvov_en` = 1, port voltage (0.1 V units) below UV_LIM or above OV_LIM held for UVOV_TICKS ticks enters the voltage fault (status 9). With `uvov_en` = 0 such a voltage has no effect.
- R9: Every fault state drives `irq_n` to 0 and opens the switch. `soft_rst` returns the port to detection with class 0, and so does taking `port_en` low and then high again.
- R10: `temp_hot` while detecting, classifying, backing off or powered enters the thermal fault (status 10).
- R11: The class code stays unchanged outside classification, except that `soft_rst` clears it.
- R12: Timers ignore a powered port until its first measurement strobe after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| port_en | input | 1 | Port enable |
| soft_rst | input | 1 | Software reset pulse |
| backoff_sel | input | 1 | 1 = wait before retrying detection |
| disc_dis | input | 1 | 1 = disconnect removal disabled |
| uvov_en | input | 1 | 1 = voltage fault check enabled |
| temp_hot | input | 1 | Die over-temperature flag |
| sig_valid | input | 1 | Signature measurement strobe |
| sig_res | input | 10 | Signature resistance, 100 Ω units |
| cls_valid | input | 1 | Classification measurement strobe |
| cls_cur | input | 10 | Classification current, 0.1 mA units |
| meas_valid | input | 1 | Powered-port measurement strobe |
| port_cur | input | 14 | Port current, 0.1 mA units |
| port_volt | input | 10 | Port voltage, 0.1 V units |
| pwr_en | output | 1 | Port power switch enable |
| class_code | output | 3 | Latched class 0..4 |
| status | output | 4 | Port state / fault code |
| irq_n | output | 1 | Active-low fault interrupt |

## Verification
A wrong sequencer state shows up on `status` and `pwr_en` on the clock edge after the stimulus that exposes it. A detection state that accepts a bad signature would show status 4 one cycle after the strobe. A dwell counter that is off by one changes the fault entry by exactly one tick, so the bench checks both one tick before each limit and at the limit. A corrupted class register shows on `class_code` through later phases, where it must hold still.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

    typedef enum logic [2:0] {
        ST_INIT    = 3'd0,
        ST_OFF     = 3'd1,
        ST_DETECT  = 3'd2,
        ST_BACKOFF = 3'd3,
        ST_CLASS   = 3'd4,
        ST_POWER   = 3'd5,
        ST_FAULT   = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_OC   = 2'd1,
        FK_UVOV = 2'd2,
        FK_TSD  = 2'd3
    } fault_kind_e;

    localparam logic [3:0] STS_INIT    = 4'd0;
    localparam logic [3:0] STS_OFF     = 4'd1;
    localparam logic [3:0] STS_DETECT  = 4'd2;
    localparam logic [3:0] STS_BACKOFF = 4'd3;
    localparam logic [3:0] STS_CLASS   = 4'd4;
    localparam logic [3:0] STS_POWER   = 4'd5;
    localparam logic [3:0] STS_F_OC    = 4'd8;
    localparam logic [3:0] STS_F_UVOV  = 4'd9;
    localparam logic [3:0] STS_F_TSD   = 4'd10;

endpackage

// File: rtl/poe_sig_window.sv
module poe_sig_window #(
    parameter int RES_W  = 10,
    parameter int SIG_LO = 190,
    parameter int SIG_HI = 265
) (
    input  logic [RES_W-1:0] res,
    output logic             ok
);
    always_comb begin
        ok = (int'(res) >= SIG_LO) && (int'(res) <= SIG_HI);
    end
endmodule

// File: rtl/poe_class_decode.sv
module poe_class_decode #(
    parameter int CLS_W = 10,
    parameter int T01   = 65,
    parameter int T12   = 145,
    parameter int T23   = 230,
    parameter int T34   = 330,
    parameter int T40   = 480
) (
    input  logic [CLS_W-1:0] cur,
    output logic [2:0]       cls
);
    localparam int NTH = 5;
    logic [NTH-1:0] above;
    int             thr [NTH];

    always_comb begin
        thr[0] = T01;
        thr[1] = T12;
        thr[2] = T23;
        thr[3] = T34;
        thr[4] = T40;
    end

    for (genvar g = 0; g < NTH; g++) begin : g_cmp
        assign above[g] = int'(cur) >= thr[g];
    end

    always_comb begin
        if (above[4])      cls = 3'd0;
        else if (above[3]) cls = 3'd4;
        else if (above[2]) cls = 3'd3;
        else if (above[1]) cls = 3'd2;
        else if (above[0]) cls = 3'd1;
        else               cls = 3'd0;
    end
endmodule

// File: rtl/poe_dwell_timer.sv
module poe_dwell_timer #(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == W'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (!run)                  cnt_d = '0;
        else if (tick && !expired) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_cnt_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= W'(LIMIT));
    p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
    import poe_seq_pkg::*;
#(
    parameter int RES_W         = 10,
    parameter int CLS_W         = 10,
    parameter int I_W           = 14,
    parameter int V_W           = 10,
    parameter int SIG_LO        = 190,
    parameter int SIG_HI        = 265,
    parameter int OC_LIM        = 6150,
    parameter int DISC_LIM      = 75,
    parameter int UV_LIM        = 427,
    parameter int OV_LIM        = 550,
    parameter int START_TICKS   = 1000,
    parameter int BACKOFF_TICKS = 2000,
    parameter int OC_TICKS      = 60,
    parameter int DISC_TICKS    = 350,
    parameter int UVOV_TICKS    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             port_en,
    input  logic             soft_rst,
    input  logic             backoff_sel,
    input  logic             disc_dis,
    input  logic             uvov_en,
    input  logic             temp_hot,
    input  logic             sig_valid,
    input  logic [RES_W-1:0] sig_res,
    input  logic             cls_valid,
    input  logic [CLS_W-1:0] cls_cur,
    input  logic             meas_valid,
    input  logic [I_W-1:0]   port_cur,
    input  logic [V_W-1:0]   port_volt,
    output logic             pwr_en,
    output logic [2:0]       class_code,
    output logic [3:0]       status,
    output logic             irq_n
);
    localparam int SEQ_MAX = (START_TICKS > BACKOFF_TICKS) ? START_TICKS : BACKOFF_TICKS;
    localparam int SEQ_W   = $clog2(SEQ_MAX + 1);

    typedef struct packed {
        seq_state_e  state;
        fault_kind_e fault;
        logic [2:0]  cls;
        logic [SEQ_W-1:0] cnt;
        logic [I_W-1:0] cur;
        logic [V_W-1:0] volt;
        logic        seen;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic       sig_ok;
    logic [2:0] cls_dec;
    logic       oc_run, disc_run, uvov_run;
    logic       oc_exp, disc_exp, uvov_exp;
    logic       watching;

    poe_sig_window #(.RES_W(RES_W), .SIG_LO(SIG_LO), .SIG_HI(SIG_HI)) u_sig (
        .res (sig_res),
        .ok  (sig_ok)
    );

    poe_class_decode #(.CLS_W(CLS_W)) u_cls (
        .cur (cls_cur),
        .cls (cls_dec)
    );

    assign watching = (r_q.state == ST_POWER) && r_q.seen;
    assign oc_run   = watching && (int'(r_q.cur) > OC_LIM);
    assign disc_run = watching && !disc_dis && (int'(r_q.cur) < DISC_LIM);
    assign uvov_run = watching && uvov_en &&
                      ((int'(r_q.volt) < UV_LIM) || (int'(r_q.volt) > OV_LIM));

    poe_dwell_timer #(.LIMIT(OC_TICKS)) u_oc_tmr (
        .clk (clk), .rst_n (rst_n), .run (oc_run), .tick (tick), .expired (oc_exp)
    );
    poe_dwell_timer #(.LIMIT(DISC_TICKS)) u_disc_tmr (
        .clk (clk), .rst_n (rst_n), .run (disc_run), .tick (tick), .expired (disc_exp)
    );
    poe_dwell_timer #(.LIMIT(UVOV_TICKS)) u_uvov_tmr (
        .clk (clk), .rst_n (rst_n), .run (uvov_run), .tick (tick), .expired (uvov_exp)
    );

    always_comb begin
        r_d = r_q;
        if (meas_valid && r_q.state == ST_POWER) begin
            r_d.cur  = port_cur;
            r_d.volt = port_volt;
            r_d.seen = 1'b1;
        end

        unique case (r_q.state)
            ST_INIT: begin
                if (r_q.cnt == SEQ_W'(START_TICKS)) begin
                    r_d.cnt   = '0;
                    r_d.state = port_en ? ST_DETECT : ST_OFF;
                end else if (tick) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_OFF: begin
                if (port_en) r_d.state = ST_DETECT;
            end
            ST_DETECT: begin
                if (sig_valid) begin
                    if (sig_ok) begin
                        r_d.state = ST_CLASS;
                    end else if (backoff_sel) begin
                        r_d.state = ST_BACKOFF;
                        r_d.cnt   = '0;
                    end
                end
            end
            ST_BACKOFF: begin
                if (r_q.cnt == SEQ_W'(BACKOFF_TICKS)) begin
                    r_d.state = ST_DETECT;
                    r_d.cnt   = '0;
                end else if (tick) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_CLASS: begin
                if (cls_valid) begin
                    r_d.cls   = cls_dec;
                    r_d.state = ST_POWER;
                    r_d.seen  = 1'b0;
                end
            end
            ST_POWER: begin
                if (oc_exp) begin
                    r_d.state = ST_FAULT;
                    r_d.fault = FK_OC;
                end else if (uvov_exp) begin
                    r_d.state = ST_FAULT;
                    r_d.fault = FK_UVOV;
                end else if (disc_exp) begin
                    r_d.state = ST_DETECT;
                end
            end
            ST_FAULT: begin
            end
            default: r_d.state = ST_OFF;
        endcase

        if (temp_hot && (r_q.state inside {ST_DETECT, ST_BACKOFF, ST_CLASS, ST_POWER})) begin
            r_d.state = ST_FAULT;
            r_d.fault = FK_TSD;
        end
        if (r_q.state != ST_INIT) begin
            if (!port_en) begin
                r_d.state = ST_OFF;
                r_d.fault = FK_NONE;
            end
            if (soft_rst) begin
                r_d.state = port_en ? ST_DETECT : ST_OFF;
                r_d.fault = FK_NONE;
                r_d.cls   = '0;
            end
        end
        if (r_d.state != ST_POWER) r_d.seen = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_INIT, fault: FK_NONE, cls: '0, cnt: '0,
                     cur: '0, volt: '0, seen: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.state)
            ST_INIT:    status = STS_INIT;
            ST_OFF:     status = STS_OFF;
            ST_DETECT:  status = STS_DETECT;
            ST_BACKOFF: status = STS_BACKOFF;
            ST_CLASS:   status = STS_CLASS;
            ST_POWER:   status = STS_POWER;
            ST_FAULT: begin
                case (r_q.fault)
                    FK_OC:   status = STS_F_OC;
                    FK_UVOV: status = STS_F_UVOV;
                    default: status = STS_F_TSD;
                endcase
            end
            default:    status = STS_OFF;
        endcase
    end

    assign pwr_en     = (r_q.state == ST_POWER);
    assign irq_n      = (r_q.state != ST_FAULT);
    assign class_code = r_q.cls;

    // R4: the switch only closes coming out of classification
    p_pwr_after_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> $past(r_q.state) == ST_CLASS);
    // R2: classification is reached only on an in-band signature
    p_sig_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CLASS && $past(r_q.state) == ST_DETECT) |-> $past(sig_valid && sig_ok));
    // R9: an active interrupt never coexists with a closed switch
    p_irq_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> !pwr_en);
    // R11: class holds outside classification unless software reset
    p_class_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_CLASS && !soft_rst) |=> $stable(class_code));
    // R10: overheating while powered forces the thermal fault
    p_thermal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_hot && r_q.state == ST_POWER && port_en && !soft_rst) |=> status == STS_F_TSD);
    // R12: no dwell timer runs before the first powered measurement
    p_no_early_run_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.seen |-> !(oc_run || disc_run || uvov_run));
endmodule

// File: tb/poe_port_seq_tb.sv
module poe_port_seq_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  ST_T = 3, BO_T = 5, OC_T = 4, DC_T = 6, UV_T = 2;

    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic        port_en = 1'b1, soft_rst = 1'b0, backoff_sel = 1'b0;
    logic        disc_dis = 1'b0, uvov_en = 1'b0, temp_hot = 1'b0;
    logic        sig_valid = 1'b0, cls_valid = 1'b0, meas_valid = 1'b0;
    logic [9:0]  sig_res = '0, cls_cur = '0, port_volt = '0;
    logic [13:0] port_cur = '0;
    logic        pwr_en, irq_n;
    logic [2:0]  class_code;
    logic [3:0]  status;

    int total = 0, bad = 0;
    bit done = 0;

    typedef struct {
        string      tag;
        logic [3:0] sts;
        logic [2:0] cls;
        logic       pwr;
        logic       irq;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    poe_port_seq #(
        .START_TICKS(ST_T), .BACKOFF_TICKS(BO_T), .OC_TICKS(OC_T),
        .DISC_TICKS(DC_T), .UVOV_TICKS(UV_T)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .port_en(port_en), .soft_rst(soft_rst),
        .backoff_sel(backoff_sel), .disc_dis(disc_dis), .uvov_en(uvov_en),
        .temp_hot(temp_hot), .sig_valid(sig_valid), .sig_res(sig_res),
        .cls_valid(cls_valid), .cls_cur(cls_cur), .meas_valid(meas_valid),
        .port_cur(port_cur), .port_volt(port_volt), .pwr_en(pwr_en),
        .class_code(class_code), .status(status), .irq_n(irq_n)
    );

    // monitor: compare queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (status !== e.sts || class_code !== e.cls || pwr_en !== e.pwr || irq_n !== e.irq) begin
                bad++;
                $display("FAIL %s: got sts=%0d cls=%0d pwr=%0b irq_n=%0b exp sts=%0d cls=%0d pwr=%0b irq_n=%0b",
                         e.tag, status, class_code, pwr_en, irq_n, e.sts, e.cls, e.pwr, e.irq);
            end
        end
    end

    task automatic expect_out(string tag, logic [3:0] s, logic [2:0] c);
        exp_t e;
        e.tag = tag; e.sts = s; e.cls = c;
        e.pwr = (s == 4'd5);
        e.irq = !(s >= 4'd8);
        sb.push_back(e);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(posedge clk); #1; tick = 1'b0; @(posedge clk); #1;
        end
        cyc(1);
    endtask

    task automatic sig(int r);
        sig_res = 10'(r); sig_valid = 1'b1; @(posedge clk); #1; sig_valid = 1'b0; cyc(1);
    endtask

    task automatic cls(int c);
        cls_cur = 10'(c); cls_valid = 1'b1; @(posedge clk); #1; cls_valid = 1'b0; cyc(1);
    endtask

    task automatic meas(int i, int v);
        port_cur = 14'(i); port_volt = 10'(v);
        meas_valid = 1'b1; @(posedge clk); #1; meas_valid = 1'b0; cyc(1);
    endtask

    task automatic regrant();
        port_en = 1'b0; cyc(2); port_en = 1'b1; cyc(2);
    endtask

    task automatic class_pass(string tag, int c, logic [2:0] k);
        regrant();
        sig(220);
        cls(c);
        expect_out(tag, 4'd5, k);
    endtask

    initial begin
        cyc(3);
        expect_out("R1 reset state", 4'd0, 3'd0);
        rst_n = 1'b1; cyc(1);
        ticks(ST_T - 1);
        expect_out("R1 start delay not done", 4'd0, 3'd0);
        ticks(1);
        expect_out("R1 start delay done -> detect", 4'd2, 3'd0);

        sig(120);
        expect_out("R2/R6 low signature, no backoff", 4'd2, 3'd0);
        sig(266);
        expect_out("R2 just above band rejected", 4'd2, 3'd0);
        backoff_sel = 1'b1;
        sig(300);
        expect_out("R6 enter backoff", 4'd3, 3'd0);
        ticks(BO_T - 1);
        expect_out("R6 backoff one tick short", 4'd3, 3'd0);
        ticks(1);
        expect_out("R6 backoff ends", 4'd2, 3'd0);
        backoff_sel = 1'b0;

        sig(190);
        expect_out("R2 low band edge accepted", 4'd4, 3'd0);
        cls(100);
        expect_out("R3/R4 class 1 powered", 4'd5, 3'd1);

        ticks(OC_T + 2);
        expect_out("R12 no measurement, no dwell", 4'd5, 3'd1);
        meas(3000, 480);
        meas(6200, 480);
        ticks(OC_T - 1);
        expect_out("R5 overcurrent one tick short", 4'd5, 3'd1);
        ticks(1);
        expect_out("R5/R9 overcurrent fault", 4'd8, 3'd1);

        soft_rst = 1'b1; cyc(1); soft_rst = 1'b0;
        expect_out("R9 soft reset to detect", 4'd2, 3'd0);

        sig(265);
        cls(500);
        expect_out("R3 above 48 mA is class 0", 4'd5, 3'd0);
        meas(50, 480);
        ticks(DC_T - 1);
        expect_out("R7 disconnect one tick short", 4'd5, 3'd0);
        ticks(1);
        expect_out("R7 disconnect removes power", 4'd2, 3'd0);

        disc_dis = 1'b1;
        sig(220);
        cls(250);
        meas(50, 480);
        ticks(DC_T + 3);
        expect_out("R7 disconnect disabled", 4'd5, 3'd3);

        meas(3000, 400);
        ticks(UV_T + 3);
        expect_out("R8 undervoltage check off", 4'd5, 3'd3);
        uvov_en = 1'b1; cyc(1);
        ticks(UV_T - 1);
        expect_out("R8 voltage fault one tick short", 4'd5, 3'd3);
        ticks(1);
        expect_out("R8 undervoltage fault", 4'd9, 3'd3);
        expect_out("R11 class held in fault", 4'd9, 3'd3);
        disc_dis = 1'b0;

        regrant();
        expect_out("R9 re-enable to detect", 4'd2, 3'd3);
        sig(200);
        cls(340);
        meas(3000, 560);
        ticks(UV_T);
        expect_out("R8 overvoltage fault", 4'd9, 3'd4);
        uvov_en = 1'b0;

        regrant();
        sig(200);
        cls(340);
        expect_out("R3 class 4", 4'd5, 3'd4);
        temp_hot = 1'b1; cyc(1); temp_hot = 1'b0;
        expect_out("R10 thermal fault", 4'd10, 3'd4);

        class_pass("R3 64 is class 0", 64, 3'd0);
        class_pass("R3 65 is class 1", 65, 3'd1);
        class_pass("R3 145 is class 2", 145, 3'd2);
        class_pass("R3 229 is class 2", 229, 3'd2);
        class_pass("R3 230 is class 3", 230, 3'd3);
        class_pass("R3 479 is class 4", 479, 3'd4);
        class_pass("R3 480 is class 0", 480, 3'd0);

        port_en = 1'b0; cyc(1);
        expect_out("R9 disable opens switch", 4'd1, 3'd0);

        cyc(3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running exp finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule